// File: doc/BRIEF.md
# Pulse-Width Serial Word Transmitter

This block turns a parallel word into a serial stream on one output line. Every bit is sent as a cell of four timebase ticks. The line goes low for the first tick, carries the bit value for the next two ticks, and is high for the fourth tick. Because of this, every cell starts with a falling edge, so a receiver can resynchronise on each bit, whatever the data.

The block runs on the system clock. A one-cycle tick enable, normally derived from a 1 MHz timebase, marks when the line may change. The user presents a word of up to `MAX_BITS` bits and a bit count, then pulses a start strobe while the block is idle. The block sends bit 0 first, then bit 1, and so on, until it has sent the requested number of cells. It then reports completion with a single-cycle done pulse. While idle, the line rests high.

Top module: `cellword_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `line_out` is 1. After reset, `busy` and `done` are both 0.
- R2: A `start` pulse is accepted only in a cycle where `busy` is low. A `start` pulse while `busy` is high has no effect on the line sequence, on `busy` or on `done`.
- R3: `data_in` and `bit_count` are captured in the cycle where `start` is accepted. Later changes to them do not affect the transfer in progress.
- R4: Each bit cell lasts four ticks. The line value for each tick is, in order: 0, then the bit, then the bit, then 1. `line_out` changes only on the clock edge that samples `tick_en` high.
- R5: Cells are sent from bit index 0 upward. The number of cells is exactly the accepted count.
- R6: `done` is a pulse of one clock cycle. It appears on the edge of the first tick after the last cell's high phase, and `busy` falls on that same edge.
- R7: A start accepted with `bit_count` = 0 raises `done` on the next edge. In that case `busy` never rises and the line stays high.
- R8: A start accepted with a nonzero count raises `busy` on the next edge. `busy` can only fall on an edge that samples `tick_en` high.
- R9: A count above `MAX_BITS` is treated as `MAX_BITS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle timebase tick; the line moves only on these cycles |
| start | input | 1 | Request to send; taken only while idle |
| data_in | input | MAX_BITS | Word to send; bit 0 goes first |
| bit_count | input | CNT_W | Number of bits to send (clamped to MAX_BITS) |
| line_out | output | 1 | Serial line, high at rest |
| busy | output | 1 | High while a transfer is running |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The bench sends words under three tick patterns:
- Ticks every fourth clock. This is the nominal spacing.
- Ticks on every clock. This separates errors in the tick gating from errors in the cell order.
- Ticks at random intervals. This exposes any phase that advances without a tick.

Random data of random lengths is checked against a sequence computed tick by tick, which catches wrong bit order, a wrong phase order and wrong cell counts. Directed cases cover:
- a length of one;
- the full width;
- a zero count;
- counts above the width, which must be clamped;
- a start strobe during a busy transfer, which must be ignored;
- input changes after acceptance, which must not alter what is sent.

// File: rtl/cwtx_pkg.sv
// Shared types for the cell-coded serial word transmitter.
// Assumes nothing beyond a synchronous design on one clock.
package cwtx_pkg;

    // Controller states
    typedef enum logic [1:0] {
        CT_IDLE = 2'd0,
        CT_SEND = 2'd1,
        CT_TAIL = 2'd2
    } ctl_state_e;

    // Position inside one four-tick bit cell
    typedef enum logic [1:0] {
        PH_LOW    = 2'd0,
        PH_DATA_A = 2'd1,
        PH_DATA_B = 2'd2,
        PH_HIGH   = 2'd3
    } cell_phase_e;

endpackage

// File: rtl/cwtx_phase_ctr.sv
// Tracks the tick position inside a bit cell.
// Assumes: adv is asserted only on tick cycles of an active transfer;
// clr restarts the cell at its low phase.
module cwtx_phase_ctr
    import cwtx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        adv,
    output cell_phase_e phase,
    output logic        cell_end
);

    cell_phase_e phase_q;

    // Purpose: step through the four phases, wrapping after the high phase
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= PH_LOW;
        end else if (adv) begin
            case (phase_q)
                PH_LOW:    phase_q <= PH_DATA_A;
                PH_DATA_A: phase_q <= PH_DATA_B;
                PH_DATA_B: phase_q <= PH_HIGH;
                default:   phase_q <= PH_LOW;
            endcase
        end
    end

    assign phase    = phase_q;
    assign cell_end = adv && (phase_q == PH_HIGH);

endmodule

// File: rtl/cwtx_word_store.sv
// Holds the captured word and the number of cells still to send.
// Assumes: load and shift are never high together.
// The current bit is always word bit 0, and the word shifts right once per cell.
module cwtx_word_store #(
    parameter int MAX_BITS = 86,
    parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift,
    input  logic [MAX_BITS-1:0] data_in,
    input  logic [CNT_W-1:0]    count_in,
    output logic                cur_bit,
    output logic                last_cell,
    output logic                zero_req
);

    localparam logic [CNT_W-1:0] CAP     = CNT_W'(MAX_BITS);
    localparam int               CNT_TOP = (1 << CNT_W) - 1;

    logic [MAX_BITS-1:0] word_q;
    logic [CNT_W-1:0]    rem_q;
    logic [CNT_W-1:0]    eff_cnt;

    // Purpose: limit the requested count to the word width when the field can exceed it
    generate
        if (CNT_TOP > MAX_BITS) begin : g_clamp
            assign eff_cnt = (count_in > CAP) ? CAP : count_in;
        end else begin : g_pass
            assign eff_cnt = count_in;
        end
    endgenerate

    // Purpose: capture the word at start, then drop one bit per finished cell
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            word_q <= data_in;
            rem_q  <= eff_cnt;
        end else if (shift) begin
            word_q <= word_q >> 1;
            rem_q  <= rem_q - CNT_W'(1);
        end
    end

    assign cur_bit   = word_q[0];
    assign last_cell = (rem_q == CNT_W'(1));
    assign zero_req  = (count_in == '0);

endmodule

// File: rtl/cwtx_ctrl.sv
// Transfer controller.
// Accepts a start only while idle and runs cells until the last one ends.
// It then waits one more tick, so that the final high phase keeps its full length, before pulsing done.
// Assumes tick_en is a single-cycle enable.
module cwtx_ctrl
    import cwtx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick_en,
    input  logic zero_req,
    input  logic cell_end,
    input  logic last_cell,
    output logic load,
    output logic advance,
    output logic busy,
    output logic done
);

    ctl_state_e state_q, state_d;
    logic       done_q, done_d;

    // Purpose: next-state and strobe decode
    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        load    = 1'b0;
        case (state_q)
            CT_IDLE: begin
                if (start) begin
                    if (zero_req) begin
                        done_d = 1'b1;
                    end else begin
                        load    = 1'b1;
                        state_d = CT_SEND;
                    end
                end
            end
            CT_SEND: begin
                if (cell_end && last_cell) begin
                    state_d = CT_TAIL;
                end
            end
            CT_TAIL: begin
                if (tick_en) begin
                    done_d  = 1'b1;
                    state_d = CT_IDLE;
                end
            end
            default: state_d = CT_IDLE;
        endcase
    end

    // Purpose: state and done registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CT_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    assign advance = (state_q == CT_SEND) && tick_en;
    assign busy    = (state_q != CT_IDLE);
    assign done    = done_q;

endmodule

// File: rtl/cwtx_line_drv.sv
// Registered line driver.
// On each advancing tick it drives the level that belongs to the current phase.
// Otherwise it holds the line. Reset leaves the line high.
module cwtx_line_drv
    import cwtx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    input  cell_phase_e phase,
    input  logic        cur_bit,
    output logic        line
);

    logic line_q;

    // Purpose: map the cell phase to a line level, only on tick cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b1;
        end else if (adv) begin
            case (phase)
                PH_LOW:    line_q <= 1'b0;
                PH_DATA_A: line_q <= cur_bit;
                PH_DATA_B: line_q <= cur_bit;
                default:   line_q <= 1'b1;
            endcase
        end
    end

    assign line = line_q;

endmodule

// File: rtl/cellword_tx.sv
// Top level of the cell-coded serial word transmitter.
// Sends bit 0 first. Each bit is a four-tick cell: low, bit, bit, high.
// Assumes tick_en comes from the same clock domain as clk.
module cellword_tx
    import cwtx_pkg::*;
#(
    parameter int MAX_BITS = 86,
    parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                start,
    input  logic [MAX_BITS-1:0] data_in,
    input  logic [CNT_W-1:0]    bit_count,
    output logic                line_out,
    output logic                busy,
    output logic                done
);

    logic        load, advance, cell_end, cur_bit, last_cell, zero_req;
    cell_phase_e phase;

    cwtx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tick_en   (tick_en),
        .zero_req  (zero_req),
        .cell_end  (cell_end),
        .last_cell (last_cell),
        .load      (load),
        .advance   (advance),
        .busy      (busy),
        .done      (done)
    );

    cwtx_phase_ctr u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (load),
        .adv      (advance),
        .phase    (phase),
        .cell_end (cell_end)
    );

    cwtx_word_store #(
        .MAX_BITS (MAX_BITS),
        .CNT_W    (CNT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .shift     (cell_end),
        .data_in   (data_in),
        .count_in  (bit_count),
        .cur_bit   (cur_bit),
        .last_cell (last_cell),
        .zero_req  (zero_req)
    );

    cwtx_line_drv u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (advance),
        .phase   (phase),
        .cur_bit (cur_bit),
        .line    (line_out)
    );

endmodule

// File: rtl/cellword_tx_chk.sv
// Port-level protocol checker for cellword_tx, attached by bind.
module cellword_tx_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             start,
    input logic [CNT_W-1:0] bit_count,
    input logic             line_out,
    input logic             busy,
    input logic             done
);

    // R1: idle line rests high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_out);

    // R4: line moves only after a sampled tick
    p_line_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_out) |-> $past(tick_en));

    // R6: done lasts one cycle unless a new zero-length start follows at once
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(start && bit_count == '0)) |=> !done);

    // R6: done only appears while idle
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: a zero count gives done next cycle and no busy
    p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && bit_count == '0) |=> (done && !busy));

    // R8: a nonzero start raises busy next cycle
    p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && bit_count != '0) |=> busy);

    // R8: busy only falls on a tick
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_en) |=> busy);

endmodule

bind cellword_tx cellword_tx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .start     (start),
    .bit_count (bit_count),
    .line_out  (line_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/cellword_tx_test.sv
module cellword_tx_test;
    localparam int CLK_NS = 10;
    localparam int MAXB   = 86;
    localparam int CW     = $clog2(MAXB + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick_en = 1'b0;
    logic            start = 1'b0;
    logic [MAXB-1:0] data_in = '0;
    logic [CW-1:0]   bit_count = '0;
    logic            line_out, busy, done;

    int checks = 0, failures = 0;
    int tick_mode = 0, div = 0;
    int ncap = 0, done_cnt = 0, linechg_err = 0, idle_err = 0, wide_err = 0, done_busy_err = 0;
    logic cap [0:399];
    logic prev_tick = 0, prev_busy = 0, prev_line = 1, prev_done = 0;

    cellword_tx #(.MAX_BITS(MAXB)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
        .data_in(data_in), .bit_count(bit_count),
        .line_out(line_out), .busy(busy), .done(done)
    );

    always #(CLK_NS/2) clk = ~clk;

    // tick generator, driven just after the rising edge
    always @(posedge clk) begin
        #1;
        case (tick_mode)
            0: begin div = (div + 1) % 4; tick_en = (div == 0); end
            1: tick_en = 1'b1;
            default: tick_en = ($urandom % 3 == 0);
        endcase
    end

    // port monitor at the falling edge; prev_* holds what the last rising edge saw
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_tick && prev_busy) begin
                if (ncap < 400) cap[ncap] = line_out;
                ncap++;
            end
            if (line_out !== prev_line && !prev_tick) linechg_err++;
            if (!busy && line_out !== 1'b1) idle_err++;
            if (done) begin
                done_cnt++;
                if (busy) done_busy_err++;
                if (prev_done) wide_err++;
            end
        end
        prev_tick = tick_en;
        prev_busy = busy;
        prev_line = line_out;
        prev_done = done;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff_len(input int c);
        return (c > MAXB) ? MAXB : c;
    endfunction

    // expected line value for captured tick k of a transfer
    function automatic logic exp_line(input logic [MAXB-1:0] d, input int len, input int k);
        if (k >= 4 * len) return 1'b1;
        case (k % 4)
            0: return 1'b0;
            1, 2: return d[k / 4];
            default: return 1'b1;
        endcase
    endfunction

    task automatic send_word(input logic [MAXB-1:0] d, input int c, input bit poke);
        int len = eff_len(c);
        int mism = 0;
        int first_bad = -1;
        int waited = 0;
        int ncap_end;
        ncap = 0; done_cnt = 0; linechg_err = 0; idle_err = 0; wide_err = 0; done_busy_err = 0;
        @(posedge clk); #2;
        start = 1'b1; data_in = d; bit_count = CW'(c);
        @(posedge clk); #2;
        start = 1'b0;
        data_in = {$urandom, $urandom, $urandom};  // R3: changes after acceptance
        bit_count = CW'($urandom);
        @(negedge clk);
        if (len == 0) begin
            chk(done === 1'b1 && busy === 1'b0, "R7 done next cycle, no busy", {done, busy}, 2'b10);
        end else begin
            chk(busy === 1'b1, "R8 busy after start", busy, 1);
        end
        if (poke && len > 0) begin
            @(posedge clk); #2;
            start = 1'b1; data_in = ~d; bit_count = CW'(MAXB);  // R2: ignored while busy
            @(posedge clk); #2;
            start = 1'b0;
        end
        while (done_cnt == 0 && waited < 8000) begin
            @(negedge clk);
            waited++;
        end
        chk(done_cnt == 1, "R6 done seen once", done_cnt, 1);
        ncap_end = ncap;
        if (len == 0) begin
            chk(ncap_end == 0, "R7 no line activity", ncap_end, 0);
        end else begin
            chk(ncap_end == 4 * len + 1, "R5 tick count incl. tail", ncap_end, 4 * len + 1);
            for (int k = 0; k < ncap_end && k < 400; k++) begin
                if (cap[k] !== exp_line(d, len, k)) begin
                    mism++;
                    if (first_bad < 0) first_bad = k;
                end
            end
            chk(mism == 0, "R4 R5 cell sequence mismatches", mism, 0);
            if (mism != 0) $display("  first mismatching tick index %0d", first_bad);
        end
        repeat (30) @(negedge clk);
        chk(done_cnt == 1 && ncap == ncap_end && busy === 1'b0,
            "R2 no extra transfer", done_cnt, 1);
        chk(linechg_err == 0, "R4 line moved without tick", linechg_err, 0);
        chk(idle_err == 0, "R1 line high while idle", idle_err, 0);
        chk(wide_err == 0 && done_busy_err == 0, "R6 done width/busy", wide_err + done_busy_err, 0);
    endtask

    function automatic logic [MAXB-1:0] rand_word();
        return {$urandom, $urandom, $urandom};
    endfunction

    initial begin
        int seed = $urandom(20240611);
        seed = 0;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(line_out === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 reset state",
            {line_out, busy, done}, 3'b100);

        tick_mode = 0;
        send_word(rand_word(), 1, 0);                           // R5 single cell
        send_word({MAXB{1'b1}} ^ {(MAXB/2){2'b01}}, MAXB, 0);   // R5 full width, alternating bits
        send_word(rand_word(), 0, 0);                           // R7 zero count
        send_word(rand_word(), 127, 0);                         // R9 clamp to MAXB
        send_word(rand_word(), 100, 0);                         // R9 clamp
        send_word(rand_word(), 12, 1);                          // R2 start ignored while busy
        tick_mode = 1;
        send_word(rand_word(), 5, 1);                           // R4 ticks every cycle
        send_word('0, 9, 0);
        tick_mode = 2;
        send_word({MAXB{1'b1}}, 7, 0);
        for (int i = 0; i < 24; i++) begin
            tick_mode = int'($urandom % 3);
            send_word(rand_word(), int'($urandom % 128), ($urandom % 2) == 1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule